// File: doc/BRIEF.md
# Synchronous Serial Port with Transmit and Receive FIFOs

This block is a full-duplex synchronous serial port that hangs off a processor I/O bus. Software sees two addresses. At the data address, a write pushes a word into a four-entry transmit queue and a read pops the oldest word from a four-entry receive queue. At the control address, one register holds the mode fields, the queue levels, the interrupt thresholds, the sticky error flags and a self-clearing port reset.

Each direction has its own bit clock and frame-sync input, and both are driven from outside the block. The block passes those inputs, and the receive data, through synchronizer chains clocked by the system clock, and it acts on the rising edges of the synchronized bit clock. A hidden transmit shift register takes words from the transmit queue and sends them most significant bit first. A hidden receive shift register gathers the incoming bits and pushes each finished word into the receive queue. The external bit clock must run at less than one quarter of the system clock rate.

Top module: `sync_serial_port`

## Requirements
- R1: Each queue holds at most four words. A data-address write while the transmit queue holds four words is dropped: the level stays at 4 and that word is never sent.
- R2: A write to the data address (0xFFF0) pushes into the transmit queue. A read of the data address returns the oldest received word and pops it. Words in both queues leave in the order they arrived.
- R3: A frame-sync sampled high on a bit-clock rise while the transmitter is idle loads the oldest transmit word. The next 16 bit-clock rises drive its bits on `tx_dout`, bit 15 first, and `tx_dout` changes on no other event.
- R4: A frame-sync sampled high on a bit-clock rise while the receiver is idle arms the receiver. The next 16 rises sample `rx_din`, with the first sample becoming bit 15, and the finished word is pushed into the receive queue.
- R5: When a word completes while the receive queue is full, that word is discarded and the overrun flag (control bit 14) is set.
- R6: When a transmit frame starts with the transmit queue empty, 16 zero bits are sent and the underflow flag (control bit 15) is set.
- R7: The two error flags stay set until software writes 1 to their own bit. Writing 1 to one flag leaves the other flag unchanged.
- R8: `tx_irq` is high whenever the transmit queue level is at or below the transmit threshold (control bits 4:2).
- R9: `rx_irq` is high whenever the receive queue level is at or above the receive threshold (control bits 7:5).
- R10: Writing 1 to control bit 0 empties both queues and idles both shift registers. The mode bits, thresholds and flags are kept, and bit 0 always reads 0.
- R11: While the enable bit (control bit 1) is 0, frame syncs are ignored: no word is popped from the transmit queue and no word is pushed into the receive queue.
- R12: The control register is at 0xFFF1. Its read-only status fields are the transmit queue level (bits 10:8) and the receive queue level (bits 13:11). Reads of any other address return 0.
- R13: After reset the control register reads 0x0020 (disabled, transmit threshold 0, receive threshold 1), `tx_irq` is 1, `rx_irq` is 0 and `tx_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O bus address |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, combinational from the address |
| tx_clk_in | input | 1 | External transmit bit clock |
| tx_fs_in | input | 1 | External transmit frame sync |
| tx_dout | output | 1 | Serial transmit data |
| rx_clk_in | input | 1 | External receive bit clock |
| rx_fs_in | input | 1 | External receive frame sync |
| rx_din | input | 1 | Serial receive data |
| tx_irq | output | 1 | Transmit queue at or below threshold |
| rx_irq | output | 1 | Receive queue at or above threshold |

## Verification
The bench goes after the edges of the queues. It writes a fifth word into a full transmit queue, which an unguarded write pointer would use to overwrite the oldest entry. It completes a word into a full receive queue, where a wrong design would either replace stored data or fail to raise the overrun flag. It starts a frame with nothing to send, which should produce zeros and the underflow flag rather than stale shift-register bits.

It also clears one error flag alone, to catch a clear that hits both flags. It sends frames while the port is disabled, which a leaky enable would let pop or push words. It issues a port reset with words still queued: a design that leaves the queues or the shift register untouched would send an old word next, and one that clears the configuration would lose the thresholds.

// File: rtl/ssport_pkg.sv
package ssport_pkg;

   // control/status bit positions (software visible)
   localparam int CTL_RST      = 0;
   localparam int CTL_EN       = 1;
   localparam int CTL_TXTH_LSB = 2;
   localparam int CTL_RXTH_LSB = 5;
   localparam int ST_TXLVL_LSB = 8;
   localparam int ST_RXLVL_LSB = 11;
   localparam int ST_OVR       = 14;
   localparam int ST_UDF       = 15;
   localparam int LVL_W        = 3;
   localparam int CTL_W        = 16;

   typedef struct packed {
      logic             en;
      logic [LVL_W-1:0] tx_th;
      logic [LVL_W-1:0] rx_th;
   } ssport_cfg_t;

endpackage

// File: rtl/ssport_sync.sv
module ssport_sync #(
   parameter int N      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clk_async,
   input  logic [N-1:0] dat_async,
   output logic         clk_rise,
   output logic [N-1:0] dat_q
);
   logic [N:0] stg [STAGES];
   logic       prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         prev <= 1'b0;
      end else begin
         stg[0] <= {dat_async, clk_async};
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         prev <= stg[STAGES-1][0];
      end
   end

   assign clk_rise = stg[STAGES-1][0] & ~prev;
   assign dat_q    = stg[STAGES-1][N:1];
endmodule

// File: rtl/ssport_fifo.sv
module ssport_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   parameter int LW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; level <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; level <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ssport_tx_eng.sv
module ssport_tx_eng #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         bit_rise,
   input  logic         fs,
   input  logic         q_empty,
   input  logic [W-1:0] q_data,
   output logic         q_pop,
   output logic         underflow,
   output logic         dout
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sr;
   logic [CW-1:0] cnt;
   logic          start;

   assign start     = bit_rise && (cnt == '0) && en && fs && !clr;
   assign q_pop     = start && !q_empty;
   assign underflow = start && q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0; cnt <= '0; dout <= 1'b0;
      end else if (clr) begin
         sr <= '0; cnt <= '0; dout <= 1'b0;
      end else if (bit_rise) begin
         if (cnt == '0) begin
            if (start) begin
               sr  <= q_empty ? '0 : q_data;
               cnt <= CW'(W);
            end
         end else begin
            dout <= sr[W-1];
            sr   <= {sr[W-2:0], 1'b0};
            cnt  <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/ssport_rx_eng.sv
module ssport_rx_eng #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         bit_rise,
   input  logic         fs,
   input  logic         din,
   output logic         word_valid,
   output logic [W-1:0] word
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sr;
   logic [CW-1:0] cnt;

   assign word_valid = bit_rise && (cnt == CW'(1)) && !clr;
   assign word       = {sr[W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0; cnt <= '0;
      end else if (clr) begin
         sr <= '0; cnt <= '0;
      end else if (bit_rise) begin
         if (cnt == '0) begin
            if (en && fs) cnt <= CW'(W);
         end else begin
            sr  <= {sr[W-2:0], din};
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssport_pkg::*;
#(
   parameter int              WORD_W      = 16,
   parameter int              FIFO_DEPTH  = 4,
   parameter int              SYNC_STAGES = 2,
   parameter int              ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFFF0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFF1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              tx_clk_in,
   input  logic              tx_fs_in,
   output logic              tx_dout,
   input  logic              rx_clk_in,
   input  logic              rx_fs_in,
   input  logic              rx_din,
   output logic              tx_irq,
   output logic              rx_irq
);
   localparam int LW = $clog2(FIFO_DEPTH + 1);

   generate
      if (WORD_W < CTL_W) begin : g_bad_width
         $error("sync_serial_port: WORD_W must be at least 16");
      end
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 7) begin : g_bad_depth
         $error("sync_serial_port: FIFO_DEPTH must lie in 2..7");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sync_serial_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // bus decode
   logic sel_data, sel_ctl, ctl_wr, port_clr;
   logic tx_push, rx_pop;
   assign sel_data = (bus_addr == DATA_ADDR);
   assign sel_ctl  = (bus_addr == CTRL_ADDR);
   assign ctl_wr   = bus_wr && sel_ctl;
   assign port_clr = ctl_wr && bus_wdata[CTL_RST];
   assign tx_push  = bus_wr && sel_data;
   assign rx_pop   = bus_rd && sel_data;

   // input synchronizers
   logic tx_rise, rx_rise;
   logic tx_fs_q;
   logic [1:0] rx_q;

   ssport_sync #(.N(1), .STAGES(SYNC_STAGES)) u_tx_sync (
      .clk(clk), .rst_n(rst_n), .clk_async(tx_clk_in), .dat_async(tx_fs_in),
      .clk_rise(tx_rise), .dat_q(tx_fs_q));

   ssport_sync #(.N(2), .STAGES(SYNC_STAGES)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .clk_async(rx_clk_in), .dat_async({rx_din, rx_fs_in}),
      .clk_rise(rx_rise), .dat_q(rx_q));

   // configuration and sticky flags
   ssport_cfg_t cfg;
   logic        ovr, udf;

   // queues and engines
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic [LW-1:0]     tx_lvl, rx_lvl;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              tx_pop, tx_under, rx_valid;

   ssport_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .LW(LW)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(port_clr), .push(tx_push), .din(bus_wdata),
      .pop(tx_pop), .dout(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

   ssport_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .LW(LW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(port_clr), .push(rx_valid), .din(rx_word),
      .pop(rx_pop), .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

   ssport_tx_eng #(.W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(port_clr), .en(cfg.en), .bit_rise(tx_rise),
      .fs(tx_fs_q), .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
      .underflow(tx_under), .dout(tx_dout));

   ssport_rx_eng #(.W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(port_clr), .en(cfg.en), .bit_rise(rx_rise),
      .fs(rx_q[0]), .din(rx_q[1]), .word_valid(rx_valid), .word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.en    <= 1'b0;
         cfg.tx_th <= '0;
         cfg.rx_th <= LVL_W'(1);
         ovr       <= 1'b0;
         udf       <= 1'b0;
      end else begin
         if (ctl_wr) begin
            cfg.en    <= bus_wdata[CTL_EN];
            cfg.tx_th <= bus_wdata[CTL_TXTH_LSB +: LVL_W];
            cfg.rx_th <= bus_wdata[CTL_RXTH_LSB +: LVL_W];
         end
         if (rx_valid && rx_full)               ovr <= 1'b1;
         else if (ctl_wr && bus_wdata[ST_OVR])  ovr <= 1'b0;
         if (tx_under)                          udf <= 1'b1;
         else if (ctl_wr && bus_wdata[ST_UDF])  udf <= 1'b0;
      end
   end

   // status view
   logic [LVL_W-1:0] tx_lvl_s, rx_lvl_s;
   logic [CTL_W-1:0] st;
   assign tx_lvl_s = LVL_W'(tx_lvl);
   assign rx_lvl_s = LVL_W'(rx_lvl);

   always_comb begin
      st                             = '0;
      st[CTL_EN]                     = cfg.en;
      st[CTL_TXTH_LSB +: LVL_W]      = cfg.tx_th;
      st[CTL_RXTH_LSB +: LVL_W]      = cfg.rx_th;
      st[ST_TXLVL_LSB +: LVL_W]      = tx_lvl_s;
      st[ST_RXLVL_LSB +: LVL_W]      = rx_lvl_s;
      st[ST_OVR]                     = ovr;
      st[ST_UDF]                     = udf;
   end

   assign bus_rdata = sel_data ? rx_head : (sel_ctl ? WORD_W'(st) : '0);
   assign tx_irq    = (tx_lvl_s <= cfg.tx_th);
   assign rx_irq    = (rx_lvl_s >= cfg.rx_th);
endmodule

// File: rtl/ssport_checker.sv
module ssport_checker #(
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_push,
   input logic             tx_full,
   input logic             tx_pop,
   input logic             port_clr,
   input logic [LVL_W-1:0] tx_lvl,
   input logic [LVL_W-1:0] rx_lvl,
   input logic             rx_valid,
   input logic             rx_full,
   input logic             ovr,
   input logic             ovr_clr_req,
   input logic             tx_under,
   input logic             udf,
   input logic             tx_rise,
   input logic             tx_dout
);
   assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_full && !tx_pop && !port_clr) |=> $stable(tx_lvl));

   assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rise && !port_clr) |=> $stable(tx_dout));

   assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> ovr);

   assert_underflow_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_under |=> udf);

   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr_req) |=> ovr);

   assert_port_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      port_clr |=> (tx_lvl == '0) && (rx_lvl == '0));
endmodule

bind sync_serial_port ssport_checker #(.LVL_W(ssport_pkg::LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_full(tx_full), .tx_pop(tx_pop),
   .port_clr(port_clr), .tx_lvl(tx_lvl_s), .rx_lvl(rx_lvl_s), .rx_valid(rx_valid),
   .rx_full(rx_full), .ovr(ovr), .ovr_clr_req(ctl_wr && bus_wdata[ssport_pkg::ST_OVR]),
   .tx_under(tx_under), .udf(udf), .tx_rise(tx_rise), .tx_dout(tx_dout));

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        bclk = 1'b0, bfs = 1'b0, bdin = 1'b0;
   logic        tx_dout, tx_irq, rx_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [15:0] A_DATA = 16'hFFF0;
   localparam logic [15:0] A_CTRL = 16'hFFF1;

   // {tx word, rx word}
   localparam logic [31:0] VEC [4] = '{32'hA5C3_1234, 32'h8001_FFFF,
                                       32'h0000_7FFE, 32'hFFFF_8001};

   always #2.5 clk = ~clk;

   sync_serial_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_clk_in(bclk), .tx_fs_in(bfs),
      .tx_dout(tx_dout), .rx_clk_in(bclk), .rx_fs_in(bfs), .rx_din(bdin),
      .tx_irq(tx_irq), .rx_irq(rx_irq));

   function automatic logic [15:0] ctl(input bit en, input int txth, input int rxth,
                                       input int txl, input int rxl, input bit ov, input bit ud);
      return {ud, ov, 3'(rxl), 3'(txl), 3'(rxth), 3'(txth), en, 1'b0};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic bit_cycle(input logic fs_v, input logic din_v, output logic s);
      @(negedge clk); bfs = fs_v; bdin = din_v;
      repeat (8) @(negedge clk);
      bclk = 1'b1;
      repeat (8) @(negedge clk);
      s = tx_dout;
      bclk = 1'b0;
   endtask

   task automatic frame(input logic [15:0] rxw, output logic [15:0] txw);
      logic b;
      bit_cycle(1'b1, 1'b0, b);
      for (int i = 0; i < 16; i++) begin
         bit_cycle(1'b0, rxw[15-i], b);
         txw[15-i] = b;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] r, got;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R13 reset state, R12 layout
      bus_read(A_CTRL, r);
      chk(r, ctl(0, 0, 1, 0, 0, 0, 0), "R13 ctrl reset");
      chk(tx_irq, 1'b1, "R13 tx_irq reset");
      chk(rx_irq, 1'b0, "R13 rx_irq reset");
      chk(tx_dout, 1'b0, "R13 tx_dout reset");
      bus_read(16'h1234, r);
      chk(r, 16'h0, "R12 unmapped read");

      bus_write(A_CTRL, ctl(1, 1, 2, 0, 0, 0, 0));
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 0, 0, 0), "R12 ctrl write");

      // table walk: R3 transmit, R4 receive, R2 data address
      for (int v = 0; v < 4; v++) begin
         bus_write(A_DATA, VEC[v][31:16]);
         frame(VEC[v][15:0], got);
         chk(got, VEC[v][31:16], "R3 serial tx word");
         bus_read(A_DATA, r);
         chk(r, VEC[v][15:0], "R4 serial rx word");
      end

      // R1 fifth write dropped, R8 levels
      for (int k = 0; k < 5; k++) bus_write(A_DATA, 16'h1111 * 16'(k + 1));
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 4, 0, 0, 0), "R1 tx level capped");
      chk(tx_irq, 1'b0, "R8 tx_irq above threshold");
      for (int k = 0; k < 4; k++) begin
         frame(16'hC000 + 16'(k), got);
         chk(got, 16'h1111 * 16'(k + 1), "R2 tx order");
         if (k == 0) chk(rx_irq, 1'b0, "R9 rx_irq below threshold");
         if (k == 1) chk(rx_irq, 1'b1, "R9 rx_irq at threshold");
         if (k == 1) chk(tx_irq, 1'b0, "R8 tx_irq level 2");
         if (k == 2) chk(tx_irq, 1'b1, "R8 tx_irq at threshold");
      end

      // R5 overrun and R6 underflow in one frame
      frame(16'hDEAD, got);
      chk(got, 16'h0000, "R6 underflow sends zeros");
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 4, 1, 1), "R5 R6 flags set");
      for (int k = 0; k < 4; k++) begin
         bus_read(A_DATA, r);
         chk(r, 16'hC000 + 16'(k), "R5 stored words kept");
      end
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 0, 1, 1), "R5 overrun word discarded");

      // R7 write-one-to-clear, one at a time
      bus_write(A_CTRL, ctl(1, 1, 2, 0, 0, 1, 0));
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 0, 0, 1), "R7 clear overrun only");
      bus_write(A_CTRL, ctl(1, 1, 2, 0, 0, 0, 1));
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 0, 0, 0), "R7 clear underflow");

      // R11 disabled port ignores frames
      bus_write(A_CTRL, ctl(0, 1, 2, 0, 0, 0, 0));
      bus_write(A_DATA, 16'h3C3C);
      frame(16'hBEEF, got);
      bus_read(A_CTRL, r);
      chk(r, ctl(0, 1, 2, 1, 0, 0, 0), "R11 disabled no pop no push");

      // R10 port reset
      bus_write(A_CTRL, ctl(1, 1, 2, 0, 0, 0, 0));
      bus_write(A_DATA, 16'h6666);
      bus_write(A_DATA, 16'h7777);
      frame(16'h0F0F, got);
      chk(got, 16'h3C3C, "R10 setup frame");
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 2, 1, 0, 0), "R10 levels before reset");
      bus_write(A_CTRL, ctl(1, 1, 2, 0, 0, 0, 0) | 16'h0001);
      bus_read(A_CTRL, r);
      chk(r, ctl(1, 1, 2, 0, 0, 0, 0), "R10 queues emptied config kept");
      bus_write(A_DATA, 16'h5A5A);
      frame(16'h0001, got);
      chk(got, 16'h5A5A, "R10 fresh word after reset");
      bus_read(A_DATA, r);
      chk(r, 16'h0001, "R10 rx after reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule